// File: doc/BRIEF.md
# DRAM Page-Hit Wait-State Generator

This block sits in the access path of a memory controller for page-mode DRAM. For every accepted access it decides whether the address lies in the row that is already open. It then holds the access for the number of wait clocks that fits the case and signals completion with a one-clock ready pulse. A short in-page access skips the row cycle. A miss pays for closing the old row and opening the new one.

The row is the part of the address above the column field. The width of the column field is programmable from 9 to 12 bits, so the row comparison moves with it. Page detection can be switched off, and then every access counts as a miss. Separate 2-bit fields pick the in-page and the out-of-page wait counts, and the two use different encodings. A page-close input lets refresh logic or a configuration change forget the open row.

Top module: `dram_page_waitgen`

## Requirements
- R1: The column width is 9 + `col_sel` bits (00→9, 01→10, 10→11, 11→12). Only address bits at or above that width take part in the row comparison.
- R2: An access is a page hit only if an open row is valid and its row bits equal those of the new address. `page_hit` takes its value at the clock that accepts the access and holds it until the next accepted access.
- R3: When `page_det_en` is 0, every access is a miss and uses the out-of-page wait count.
- R4: A hit waits 1, 2, 3 or 4 clocks for `ws_hit` = 00, 01, 10, 11.
- R5: A miss waits 4, 8, 11 or 15 clocks for `ws_miss` = 00, 01, 10, 11.
- R6: If the access is accepted at clock edge E, `ready` is high for exactly one cycle, directly after edge E+N, where N is the selected wait count.
- R7: A strobe is accepted only when no access is in progress. The ready cycle does not count as in progress. A strobe during an access has no effect on the open row, the hit flag or the timing.
- R8: Every accepted access latches its row as the open row, and `row_open` is 1 from the accepting edge on.
- R9: A `page_close` pulse with no accepted access clears `row_open`. If it comes with an accepted access, that access is a miss and its row is latched as open.
- R10: After reset, `page_hit`, `row_open` and `ready` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| acc_stb | input | 1 | Access request strobe |
| acc_addr | input | ADDR_W | Access address |
| page_det_en | input | 1 | Enables page-hit detection |
| col_sel | input | 2 | Column width select |
| ws_hit | input | 2 | In-page wait-state code |
| ws_miss | input | 2 | Out-of-page wait-state code |
| page_close | input | 1 | Forget the open row |
| page_hit | output | 1 | Last accepted access was in page |
| row_open | output | 1 | An open row is held |
| ready | output | 1 | One-clock completion pulse |

## Verification
Each code of both wait-state fields is tried, so a swapped or linear encoding shows up as a wrong latency. Address pairs are chosen to share a row under one column width and differ under a narrower one. This exposes a comparison that ignores `col_sel`. Hits are also tried with detection switched off. A close on its own and a close together with a strobe are both applied, which separates the two cases of close priority. Strobes held through a long access show whether a busy access can be disturbed. A behavioural model compares all three outputs on every clock.

// File: rtl/dpw_pkg.sv
package dpw_pkg;

  localparam int MIN_COL_BITS = 9;
  localparam int WAIT_W       = 4;

  typedef logic [WAIT_W-1:0] wait_t;

  function automatic int col_bits(input logic [1:0] sel);
    return MIN_COL_BITS + int'(sel);
  endfunction

  function automatic wait_t hit_waits(input logic [1:0] code);
    return wait_t'({2'b00, code}) + wait_t'(1);
  endfunction

  function automatic wait_t miss_waits(input logic [1:0] code);
    wait_t w;
    case (code)
      2'b00:   w = wait_t'(4);
      2'b01:   w = wait_t'(8);
      2'b10:   w = wait_t'(11);
      default: w = wait_t'(15);
    endcase
    return w;
  endfunction

endpackage

// File: rtl/dpw_reset_sync.sv
module dpw_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/dpw_row_match.sv
module dpw_row_match #(
  parameter int ADDR_W = 24
) (
  input  logic [1:0]                                  col_sel,
  input  logic [ADDR_W-1:dpw_pkg::MIN_COL_BITS]       row_a,
  input  logic [ADDR_W-1:dpw_pkg::MIN_COL_BITS]       row_b,
  output logic                                        same_row
);

  localparam int ROW_LSB = dpw_pkg::MIN_COL_BITS;
  localparam int ROW_W   = ADDR_W - ROW_LSB;

  logic [ROW_W-1:0] care;
  logic [ROW_W-1:0] diff;
  int               width;

  assign width = dpw_pkg::col_bits(col_sel);

  // One comparator slice per row-candidate address bit; a slice only
  // counts when its bit lies above the selected column field.
  for (genvar j = 0; j < ROW_W; j++) begin : g_bit
    assign care[j] = ((j + ROW_LSB) >= width);
    assign diff[j] = row_a[j + ROW_LSB] ^ row_b[j + ROW_LSB];
  end

  assign same_row = ~|(care & diff);

endmodule

// File: rtl/dpw_open_row.sv
module dpw_open_row #(
  parameter int ADDR_W = 24
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  load,
  input  logic                                  close,
  input  logic [ADDR_W-1:dpw_pkg::MIN_COL_BITS] row_in,
  output logic [ADDR_W-1:dpw_pkg::MIN_COL_BITS] row_q,
  output logic                                  valid_q
);

  logic                                  upd_en;
  logic                                  valid_d;
  logic [ADDR_W-1:dpw_pkg::MIN_COL_BITS] row_d;

  always_comb begin
    upd_en  = load | close;
    valid_d = valid_q;
    row_d   = row_q;
    if (load) begin
      valid_d = 1'b1;
      row_d   = row_in;
    end else if (close) begin
      valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      row_q   <= '0;
    end else if (upd_en) begin
      valid_q <= valid_d;
      row_q   <= row_d;
    end
  end

  AST_LOAD_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (valid_q && row_q == $past(row_in))); // R8

  AST_CLOSE_FORGETS: assert property (@(posedge clk) disable iff (!rst_n)
    (close && !load) |=> !valid_q); // R9

endmodule

// File: rtl/dpw_wait_timer.sv
module dpw_wait_timer #(
  parameter int CNT_W = dpw_pkg::WAIT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] load_val,
  output logic             busy,
  output logic             ready
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             rdy_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    rdy_d  = 1'b0;
    cnt_en = start | busy;
    if (busy) begin
      cnt_d = cnt_q - CNT_W'(1);
      if (cnt_q == CNT_W'(1)) begin
        rdy_d = 1'b1;
      end
    end
    if (start) begin
      cnt_d = load_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready <= 1'b0;
    end else begin
      ready <= rdy_d;
    end
  end

  assign busy = (cnt_q != '0);

  AST_READY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> !ready); // R6

  AST_READY_AFTER_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(busy)); // R6

  AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy); // R7

  AST_LOAD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (load_val != '0)); // R4

endmodule

// File: rtl/dram_page_waitgen.sv
module dram_page_waitgen #(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_stb,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              page_det_en,
  input  logic [1:0]        col_sel,
  input  logic [1:0]        ws_hit,
  input  logic [1:0]        ws_miss,
  input  logic              page_close,
  output logic              page_hit,
  output logic              row_open,
  output logic              ready
);

  import dpw_pkg::*;

  localparam int ROW_LSB = MIN_COL_BITS;

  logic                     rst_sync_n;
  logic                     busy;
  logic                     accept;
  logic                     same_row;
  logic                     hit_now;
  logic                     hit_d;
  wait_t                    wait_sel;
  logic [ADDR_W-1:ROW_LSB]  open_row_q;
  logic                     unused_col_bits;

  assign unused_col_bits = ^acc_addr[ROW_LSB-1:0];

  dpw_reset_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  dpw_row_match #(.ADDR_W(ADDR_W)) u_match (
    .col_sel  (col_sel),
    .row_a    (acc_addr[ADDR_W-1:ROW_LSB]),
    .row_b    (open_row_q),
    .same_row (same_row)
  );

  dpw_open_row #(.ADDR_W(ADDR_W)) u_row (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .load    (accept),
    .close   (page_close),
    .row_in  (acc_addr[ADDR_W-1:ROW_LSB]),
    .row_q   (open_row_q),
    .valid_q (row_open)
  );

  dpw_wait_timer #(.CNT_W(WAIT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .start    (accept),
    .load_val (wait_sel),
    .busy     (busy),
    .ready    (ready)
  );

  always_comb begin
    accept   = acc_stb & ~busy;
    hit_now  = page_det_en & row_open & ~page_close & same_row;
    wait_sel = hit_now ? hit_waits(ws_hit) : miss_waits(ws_miss);
    hit_d    = accept ? hit_now : page_hit;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      page_hit <= 1'b0;
    end else if (accept) begin
      page_hit <= hit_d;
    end
  end

  AST_NO_HIT_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (accept && !page_det_en) |=> !page_hit); // R3

  AST_HIT_HELD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !accept |=> $stable(page_hit)); // R2

  AST_CLOSE_MISSES: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (accept && page_close) |=> (!page_hit && row_open)); // R9

endmodule

// File: tb/tb_dram_page_waitgen.sv
module tb_dram_page_waitgen;

  localparam int PER    = 10;
  localparam int ADDR_W = 24;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              acc_stb;
  logic [ADDR_W-1:0] acc_addr;
  logic              page_det_en;
  logic [1:0]        col_sel;
  logic [1:0]        ws_hit;
  logic [1:0]        ws_miss;
  logic              page_close;
  logic              page_hit;
  logic              row_open;
  logic              ready;

  int total = 0;
  int bad   = 0;
  int cycles = 0;

  always #(PER/2) clk = ~clk;

  dram_page_waitgen #(.ADDR_W(ADDR_W)) dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_stb     (acc_stb),
    .acc_addr    (acc_addr),
    .page_det_en (page_det_en),
    .col_sel     (col_sel),
    .ws_hit      (ws_hit),
    .ws_miss     (ws_miss),
    .page_close  (page_close),
    .page_hit    (page_hit),
    .row_open    (row_open),
    .ready       (ready)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model, updated at each rising edge.
  int          m_cnt;
  bit          m_busy, m_rdy, m_valid, m_hit;
  int unsigned m_open;

  function automatic int hit_tab(input int c);
    return c + 1;
  endfunction

  function automatic int miss_tab(input int c);
    int t[4] = '{4, 8, 11, 15};
    return t[c];
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_cnt = 0; m_busy = 0; m_rdy = 0; m_valid = 0; m_hit = 0; m_open = 0;
    end else begin
      bit was_busy;
      bit rdy;
      int cw;
      bit h;
      was_busy = m_busy;
      rdy = 0;
      if (was_busy) begin
        m_cnt--;
        if (m_cnt == 0) begin m_busy = 0; rdy = 1; end
      end
      if (!was_busy && acc_stb) begin
        cw = 9 + int'(col_sel);
        h = page_det_en && m_valid && !page_close &&
            ((int'(acc_addr) >> cw) == (int'(m_open) >> cw));
        m_hit   = h;
        m_cnt   = h ? hit_tab(int'(ws_hit)) : miss_tab(int'(ws_miss));
        m_busy  = 1;
        m_open  = acc_addr;
        m_valid = 1;
      end else if (page_close) begin
        m_valid = 0;
      end
      m_rdy = rdy;
    end
  end

  always @(negedge clk) begin
    chk(page_hit == m_hit,   "R2 model page_hit", page_hit, m_hit);
    chk(row_open == m_valid, "R8 model row_open", row_open, m_valid);
    chk(ready == m_rdy,      "R6 model ready",    ready,    m_rdy);
  end

  always @(posedge clk) begin
    if (cycles > 20000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // One access: strobe held for 1 + hold cycles (extra cycles use alt_a).
  task automatic access(input logic [ADDR_W-1:0] a, input bit cl, input int hold,
                        input logic [ADDR_W-1:0] alt_a, input bit exp_hit,
                        input int exp_w, input string tag);
    int k;
    @(posedge clk); #(PER/4);
    acc_stb = 1'b1; acc_addr = a; page_close = cl;
    @(posedge clk);
    k = 0;
    do begin
      @(negedge clk);
      k++;
      page_close = 1'b0;
      if (k <= hold) begin acc_stb = 1'b1; acc_addr = alt_a; end
      else acc_stb = 1'b0;
    end while (!ready && k < 40);
    chk(k - 1 == exp_w, {tag, " wait count"}, k - 1, exp_w);
    chk(page_hit == exp_hit, {tag, " hit flag"}, page_hit, exp_hit);
    chk(row_open == 1'b1, "R8 row open after access", row_open, 1);
    @(negedge clk);
    chk(ready == 1'b0, "R6 ready lasts one cycle", ready, 0);
  endtask

  task automatic simple(input logic [ADDR_W-1:0] a, input bit exp_hit,
                        input int exp_w, input string tag);
    access(a, 1'b0, 0, '0, exp_hit, exp_w, tag);
  endtask

  initial begin
    rst_n = 1'b0; acc_stb = 1'b0; acc_addr = '0; page_det_en = 1'b1;
    col_sel = 2'b00; ws_hit = 2'b00; ws_miss = 2'b00; page_close = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(page_hit == 1'b0, "R10 reset page_hit", page_hit, 0);
    chk(row_open == 1'b0, "R10 reset row_open", row_open, 0);
    chk(ready == 1'b0,    "R10 reset ready",    ready,    0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // Wait encodings, column width 9
    simple(24'h001200, 0, 4, "R5 miss code00");
    simple(24'h0012FF, 1, 1, "R4 hit code00");
    ws_hit = 2'b01; simple(24'h001234, 1, 2, "R4 hit code01");
    ws_hit = 2'b10; simple(24'h001300, 1, 3, "R4 hit code10");
    ws_hit = 2'b11; simple(24'h0013FF, 1, 4, "R4 hit code11");
    ws_miss = 2'b01; simple(24'h001400, 0, 8,  "R5 miss code01");
    ws_miss = 2'b10; simple(24'h001600, 0, 11, "R5 miss code10");
    ws_miss = 2'b11; simple(24'h001800, 0, 15, "R5 miss code11");

    // Column width selection
    ws_hit = 2'b00; ws_miss = 2'b00;
    col_sel = 2'b11; simple(24'h001FFF, 1, 1, "R1 width12 hit");
    simple(24'h002000, 0, 4, "R1 width12 miss");
    col_sel = 2'b01; simple(24'h0023FF, 1, 1, "R1 width10 hit");
    simple(24'h002400, 0, 4, "R1 width10 miss");
    col_sel = 2'b10; simple(24'h0027FF, 1, 1, "R1 width11 hit");
    simple(24'h002800, 0, 4, "R1 width11 miss");

    // Detection disabled
    page_det_en = 1'b0; simple(24'h002801, 0, 4, "R3 disabled same row");
    page_det_en = 1'b1; simple(24'h002802, 1, 1, "R3 re-enabled hit");

    // Close alone, then close with an access
    @(posedge clk); #(PER/4); page_close = 1'b1;
    @(posedge clk); #(PER/4); page_close = 1'b0;
    @(negedge clk);
    chk(row_open == 1'b0, "R9 close clears row", row_open, 0);
    simple(24'h002803, 0, 4, "R9 access after close");
    access(24'h002804, 1'b1, 0, '0, 0, 4, "R9 close with access");
    simple(24'h002805, 1, 1, "R9 row reopened");

    // Strobes during a busy access are ignored
    ws_miss = 2'b11;
    access(24'h00F000, 1'b0, 3, 24'h0FF000, 0, 15, "R7 busy strobes");
    simple(24'h00F7FF, 1, 1, "R7 open row kept");

    repeat (3) @(posedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule